// File: doc/BRIEF.md
# Video Input Path Arbiter

This block decides which of two video input paths, an analog path and a digital link, drives the shared pixel outputs. It also decides which circuitry is powered. Four activity signals enter asynchronously: horizontal sync, vertical sync, sync-on-green and the digital link clock. A fifth asynchronous input is the digital data-enable. Each activity signal gets its own presence flag. A flag rises on any edge of its signal and drops after a programmable number of reference ticks without an edge.

The choice of path follows a fixed priority. A power-down control comes first, then a manual override with a select bit, then an automatic choice made from the presence flags. In the automatic choice the select bit also breaks ties. Once the link clock is present, a second stage counts data-enable pulses and reports a lock after enough of them arrive without a long gap. Software-style control bits come in as plain synchronous inputs. The path choice, power enables and lane enables leave as registered outputs.

Top module: `vpa_ctrl`

## Requirements
- R1: Each of the four activity inputs (horizontal sync, vertical sync, sync-on-green, link clock) has its own presence flag on a status output. Any edge of the input sets the flag. The flag becomes visible on the third rising clock edge after the input changes (two synchronizer stages plus one register).
- R2: A presence flag clears once TMO_TICKS reference ticks (tick_i high for one cycle) have passed since the last edge of its input. An edge in the same cycle as a tick restarts the count.
- R3: While pwr_dn_i is 1, path_o is 2'b00 (none). In the same state ana_pwr_o, dig_pwr_o, sense_pwr_o and lane_en_o are all 0, whatever the other controls and flags are.
- R4: With pwr_dn_i at 0 and ovr_i at 1, path_o is 2'b01 (analog) when sel_i is 0 and 2'b10 (digital) when sel_i is 1. The presence flags have no effect in this mode.
- R5: With pwr_dn_i and ovr_i at 0, no presence flag gives path_o 2'b00. Analog presence alone gives 2'b01, where analog presence is the OR of the three sync flags. Link clock presence alone gives 2'b10.
- R6: With pwr_dn_i and ovr_i at 0 and both paths present, sel_i 0 gives 2'b01 and sel_i 1 gives 2'b10.
- R7: In lane_en_o, bit 0 is red, bit 1 is green and bit 2 is blue. It reads 3'b011 on the analog path when fmt422_i is 1, and 3'b111 on the analog path otherwise or on the digital path. With no path it reads 3'b000.
- R8: ana_pwr_o is 1 only when path_o is analog, and dig_pwr_o is 1 only when path_o is digital. sense_pwr_o, which keeps the sync detectors, reference and link clock detector alive, is 1 whenever pwr_dn_i is 0.
- R9: The data-enable counter runs only while the link clock flag is set and pwr_dn_i is 0. st_dlock_o rises when DE_NEED rising edges of data-enable have been counted. It clears one cycle after the link clock flag drops or power-down is asserted.
- R10: Before lock, if GAP_MAX+1 consecutive cycles pass with no data-enable rising edge, the pulse count restarts from zero.
- R11: All outputs are registered and reset to zero. A change of a control input appears on the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled reference tick, one cycle wide |
| hs_act_i | input | 1 | Horizontal sync activity (asynchronous) |
| vs_act_i | input | 1 | Vertical sync activity (asynchronous) |
| sog_act_i | input | 1 | Sync-on-green activity (asynchronous) |
| lclk_act_i | input | 1 | Digital link clock activity (asynchronous) |
| de_i | input | 1 | Digital data-enable (asynchronous) |
| pwr_dn_i | input | 1 | Power-down control, highest priority |
| ovr_i | input | 1 | Manual path override |
| sel_i | input | 1 | Path select / tie-break (0 analog, 1 digital) |
| fmt422_i | input | 1 | 4:2:2 output format on analog path |
| path_o | output | 2 | Active path: 00 none, 01 analog, 10 digital |
| ana_pwr_o | output | 1 | Analog path power enable |
| dig_pwr_o | output | 1 | Digital path power enable |
| sense_pwr_o | output | 1 | Detector and reference power enable |
| lane_en_o | output | 3 | Output lane enables {blue, green, red} |
| st_hs_o | output | 1 | Horizontal sync present |
| st_vs_o | output | 1 | Vertical sync present |
| st_sog_o | output | 1 | Sync-on-green present |
| st_lclk_o | output | 1 | Link clock present |
| st_dlock_o | output | 1 | Data-enable lock reached |

## Verification
Several properties are checked on every cycle. Power-down forces every output off on the following cycle. The override maps the select bit straight to the path. Absent flags leave no path in automatic mode. The two path power enables never assert together. Lock drops right after the link clock flag falls. The timing of the flags, the ticks needed for timeout, the tie-break choice, the DE pulse count needed for lock and the gap restart all depend on histories of stimulus. Only the bench scenarios, compared against the cycle model, can show those.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
    typedef enum logic [1:0] {
        PATH_NONE = 2'b00,
        PATH_ANA  = 2'b01,
        PATH_DIG  = 2'b10
    } path_e;

    localparam int N_MON  = 4;      // monitored activity inputs
    localparam int N_SYNC = N_MON + 1;  // plus data-enable
    localparam int IDX_LCLK = 3;
    localparam int IDX_DE   = 4;

    localparam logic [2:0] LANES_ALL = 3'b111;
    localparam logic [2:0] LANES_RG  = 3'b011;
endpackage

// File: rtl/vpa_sync.sv
module vpa_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/vpa_act_mon.sv
module vpa_act_mon #(
    parameter int TMO_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic sig_i,
    output logic live_o
);
    localparam int CW = (TMO_TICKS > 1) ? $clog2(TMO_TICKS) : 1;

    typedef struct packed {
        logic          prev;
        logic          live;
        logic [CW-1:0] cnt;
    } mon_t;

    mon_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_i;
        if (sig_i ^ st_q.prev) begin
            st_d.live = 1'b1;
            st_d.cnt  = '0;
        end else if (tick_i && st_q.live) begin
            if (st_q.cnt == CW'(TMO_TICKS - 1)) begin
                st_d.live = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_o = st_q.live;
endmodule

// File: rtl/vpa_de_lock.sv
module vpa_de_lock #(
    parameter int DE_NEED = 32,
    parameter int GAP_MAX = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic de_i,
    output logic lock_o
);
    localparam int NW = $clog2(DE_NEED + 1);
    localparam int GW = $clog2(GAP_MAX + 1);

    typedef struct packed {
        logic          prev;
        logic          lock;
        logic [NW-1:0] cnt;
        logic [GW-1:0] gap;
    } lk_t;

    lk_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = de_i;
        if (!en_i) begin
            st_d.cnt  = '0;
            st_d.gap  = '0;
            st_d.lock = 1'b0;
        end else begin
            if (de_i && !st_q.prev) begin
                st_d.gap = '0;
                if (st_q.cnt != NW'(DE_NEED)) st_d.cnt = st_q.cnt + 1'b1;
            end else if (!st_q.lock) begin
                if (st_q.gap == GW'(GAP_MAX)) begin
                    st_d.cnt = '0;
                    st_d.gap = '0;
                end else begin
                    st_d.gap = st_q.gap + 1'b1;
                end
            end
            st_d.lock = (st_d.cnt == NW'(DE_NEED));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_o = st_q.lock;
endmodule

// File: rtl/vpa_ctrl.sv
module vpa_ctrl
    import vpa_pkg::*;
#(
    parameter int TMO_TICKS = 8,
    parameter int DE_NEED   = 32,
    parameter int GAP_MAX   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       hs_act_i,
    input  logic       vs_act_i,
    input  logic       sog_act_i,
    input  logic       lclk_act_i,
    input  logic       de_i,
    input  logic       pwr_dn_i,
    input  logic       ovr_i,
    input  logic       sel_i,
    input  logic       fmt422_i,
    output logic [1:0] path_o,
    output logic       ana_pwr_o,
    output logic       dig_pwr_o,
    output logic       sense_pwr_o,
    output logic [2:0] lane_en_o,
    output logic       st_hs_o,
    output logic       st_vs_o,
    output logic       st_sog_o,
    output logic       st_lclk_o,
    output logic       st_dlock_o
);
    logic [N_SYNC-1:0] sync_w;
    logic [N_MON-1:0]  live_w;

    vpa_sync #(.W(N_SYNC)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({de_i, lclk_act_i, sog_act_i, vs_act_i, hs_act_i}),
        .q_o   (sync_w)
    );

    for (genvar g = 0; g < N_MON; g++) begin : g_mon
        vpa_act_mon #(.TMO_TICKS(TMO_TICKS)) i_mon (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i),
            .sig_i  (sync_w[g]),
            .live_o (live_w[g])
        );
    end

    vpa_de_lock #(.DE_NEED(DE_NEED), .GAP_MAX(GAP_MAX)) i_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (live_w[IDX_LCLK] & ~pwr_dn_i),
        .de_i   (sync_w[IDX_DE]),
        .lock_o (st_dlock_o)
    );

    typedef struct packed {
        path_e      path;
        logic       ana_pwr;
        logic       dig_pwr;
        logic       sense_pwr;
        logic [2:0] lanes;
    } sel_t;

    sel_t sel_d, sel_q;
    logic ana_here, dig_here;

    assign ana_here = |live_w[2:0];
    assign dig_here = live_w[IDX_LCLK];

    always_comb begin
        sel_d = '0;
        if (pwr_dn_i) begin
            sel_d.path = PATH_NONE;
        end else if (ovr_i) begin
            sel_d.path = sel_i ? PATH_DIG : PATH_ANA;
        end else begin
            unique case ({ana_here, dig_here})
                2'b00:   sel_d.path = PATH_NONE;
                2'b10:   sel_d.path = PATH_ANA;
                2'b01:   sel_d.path = PATH_DIG;
                default: sel_d.path = sel_i ? PATH_DIG : PATH_ANA;
            endcase
        end
        sel_d.sense_pwr = !pwr_dn_i;
        sel_d.ana_pwr   = (sel_d.path == PATH_ANA);
        sel_d.dig_pwr   = (sel_d.path == PATH_DIG);
        case (sel_d.path)
            PATH_ANA: sel_d.lanes = fmt422_i ? LANES_RG : LANES_ALL;
            PATH_DIG: sel_d.lanes = LANES_ALL;
            default:  sel_d.lanes = 3'b000;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign path_o      = sel_q.path;
    assign ana_pwr_o   = sel_q.ana_pwr;
    assign dig_pwr_o   = sel_q.dig_pwr;
    assign sense_pwr_o = sel_q.sense_pwr;
    assign lane_en_o   = sel_q.lanes;
    assign st_hs_o     = live_w[0];
    assign st_vs_o     = live_w[1];
    assign st_sog_o    = live_w[2];
    assign st_lclk_o   = live_w[IDX_LCLK];
endmodule

// File: rtl/vpa_ctrl_chk.sv
module vpa_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_dn_i,
    input logic       ovr_i,
    input logic       sel_i,
    input logic       fmt422_i,
    input logic [1:0] path_o,
    input logic       ana_pwr_o,
    input logic       dig_pwr_o,
    input logic       sense_pwr_o,
    input logic [2:0] lane_en_o,
    input logic       st_hs_o,
    input logic       st_vs_o,
    input logic       st_sog_o,
    input logic       st_lclk_o,
    input logic       st_dlock_o
);
    AST_PWRDN_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn_i |=> (path_o == 2'b00 && !ana_pwr_o && !dig_pwr_o && !sense_pwr_o && lane_en_o == 3'b000)); // R3

    AST_OVR_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_dn_i && ovr_i) |=> (path_o == ($past(sel_i) ? 2'b10 : 2'b01))); // R4

    AST_AUTO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_dn_i && !ovr_i && !st_hs_o && !st_vs_o && !st_sog_o && !st_lclk_o) |=> (path_o == 2'b00)); // R5

    AST_LANES_422: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_dn_i && ovr_i && !sel_i && fmt422_i) |=> (lane_en_o == 3'b011)); // R7

    AST_PWR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ana_pwr_o && dig_pwr_o)); // R8

    AST_SENSE_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_dn_i |=> sense_pwr_o); // R8

    AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_lclk_o) |=> !st_dlock_o); // R9
endmodule

bind vpa_ctrl vpa_ctrl_chk i_chk (.*);

// File: tb/test_vpa_ctrl.sv
module test_vpa_ctrl;
    localparam int TMO  = 8;
    localparam int NEED = 32;
    localparam int GAP  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 0, hs_i = 0, vs_i = 0, sog_i = 0, lclk_i = 0, de_i = 0;
    logic pwr_dn = 0, ovr = 0, sel = 0, fmt = 0;
    logic run_hs = 0, run_lclk = 0, run_de = 0;

    logic [1:0] path_o;
    logic ana_pwr_o, dig_pwr_o, sense_pwr_o;
    logic [2:0] lane_en_o;
    logic st_hs_o, st_vs_o, st_sog_o, st_lclk_o, st_dlock_o;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    vpa_ctrl #(.TMO_TICKS(TMO), .DE_NEED(NEED), .GAP_MAX(GAP)) i_vpa_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .hs_act_i(hs_i), .vs_act_i(vs_i), .sog_act_i(sog_i),
        .lclk_act_i(lclk_i), .de_i(de_i),
        .pwr_dn_i(pwr_dn), .ovr_i(ovr), .sel_i(sel), .fmt422_i(fmt),
        .path_o(path_o), .ana_pwr_o(ana_pwr_o), .dig_pwr_o(dig_pwr_o),
        .sense_pwr_o(sense_pwr_o), .lane_en_o(lane_en_o),
        .st_hs_o(st_hs_o), .st_vs_o(st_vs_o), .st_sog_o(st_sog_o),
        .st_lclk_o(st_lclk_o), .st_dlock_o(st_dlock_o)
    );

    // stimulus generators, driven away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        tick_i <= (cyc % 4 == 3);
        if (run_hs && cyc % 3 == 0) hs_i <= ~hs_i;
        if (run_lclk && cyc % 2 == 0) lclk_i <= ~lclk_i;
        de_i <= run_de && (cyc % 4 < 2);
    end

    // behavioural reference model
    bit [4:0] d1 = '0, d2 = '0, dp = '0;
    bit       m_live [4];
    int       m_age  [4];
    int       de_n = 0, de_gap = 0;
    bit       m_lock = 0;
    int       e_path = 0;
    bit [2:0] e_lanes = '0;
    bit       e_ana = 0, e_dig = 0, e_sense = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            d1 = '0; d2 = '0; dp = '0;
            foreach (m_live[k]) begin m_live[k] = 0; m_age[k] = 0; end
            de_n = 0; de_gap = 0; m_lock = 0;
            e_path = 0; e_lanes = '0; e_ana = 0; e_dig = 0; e_sense = 0;
        end else begin
            bit old_live [4];
            bit a_here, d_here, rise;
            foreach (m_live[k]) old_live[k] = m_live[k];
            for (int k = 0; k < 4; k++) begin
                if (d2[k] != dp[k]) begin
                    m_live[k] = 1; m_age[k] = 0;
                end else if (tick_i && m_live[k]) begin
                    m_age[k]++;
                    if (m_age[k] == TMO) begin m_live[k] = 0; m_age[k] = 0; end
                end
            end
            rise = d2[4] && !dp[4];
            if (!(old_live[3] && !pwr_dn)) begin
                de_n = 0; de_gap = 0; m_lock = 0;
            end else begin
                if (rise) begin
                    de_gap = 0;
                    if (de_n < NEED) de_n++;
                end else if (!m_lock) begin
                    if (de_gap == GAP) begin de_n = 0; de_gap = 0; end
                    else de_gap++;
                end
                m_lock = (de_n == NEED);
            end
            a_here = old_live[0] || old_live[1] || old_live[2];
            d_here = old_live[3];
            if (pwr_dn) e_path = 0;
            else if (ovr) e_path = sel ? 2 : 1;
            else if (a_here && d_here) e_path = sel ? 2 : 1;
            else if (a_here) e_path = 1;
            else if (d_here) e_path = 2;
            else e_path = 0;
            e_sense = !pwr_dn;
            e_ana = (e_path == 1);
            e_dig = (e_path == 2);
            e_lanes = (e_path == 0) ? 3'b000 : ((e_path == 1 && fmt) ? 3'b011 : 3'b111);
            dp = d2; d2 = d1; d1 = {de_i, lclk_i, sog_i, vs_i, hs_i};
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        chk(path_o == 2'(e_path), "R3 R4 R5 R6 path", int'(path_o), e_path);
        chk(lane_en_o == e_lanes, "R7 lanes", int'(lane_en_o), int'(e_lanes));
        chk({ana_pwr_o, dig_pwr_o, sense_pwr_o} == {e_ana, e_dig, e_sense},
            "R8 power", int'({ana_pwr_o, dig_pwr_o, sense_pwr_o}), int'({e_ana, e_dig, e_sense}));
        chk({st_hs_o, st_vs_o, st_sog_o, st_lclk_o} == {m_live[0], m_live[1], m_live[2], m_live[3]},
            "R1 R2 flags", int'({st_hs_o, st_vs_o, st_sog_o, st_lclk_o}),
            int'({m_live[0], m_live[1], m_live[2], m_live[3]}));
        chk(st_dlock_o == m_lock, "R9 R10 lock", int'(st_dlock_o), int'(m_lock));
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_n(2);
        chk(path_o == 2'b00 && lane_en_o == 3'b000 && !sense_pwr_o, "R11 reset state", int'(path_o), 0);
        wait_n(3);
        rst_n = 1'b1;
        wait_n(4);
        chk(path_o == 2'b00 && sense_pwr_o, "R5 idle seek", int'(path_o), 0);

        // analog path alone
        run_hs = 1; wait_n(20);
        chk(st_hs_o, "R1 hs flag", int'(st_hs_o), 1);
        chk(path_o == 2'b01, "R5 analog alone", int'(path_o), 1);
        chk(lane_en_o == 3'b111, "R7 analog 444", int'(lane_en_o), 7);
        chk(ana_pwr_o && !dig_pwr_o, "R8 analog power", int'(ana_pwr_o), 1);
        fmt = 1; wait_n(1);
        chk(lane_en_o == 3'b011, "R7 analog 422", int'(lane_en_o), 3);
        chk(lane_en_o == 3'b011, "R11 one-cycle update", int'(lane_en_o), 3);
        fmt = 0;

        // analog timeout
        run_hs = 0; wait_n(60);
        chk(!st_hs_o, "R2 hs timeout", int'(st_hs_o), 0);
        chk(path_o == 2'b00, "R5 none after loss", int'(path_o), 0);

        // digital path and lock
        run_lclk = 1; run_de = 1; wait_n(200);
        chk(path_o == 2'b10, "R5 digital alone", int'(path_o), 2);
        chk(st_dlock_o, "R9 lock reached", int'(st_dlock_o), 1);
        chk(dig_pwr_o && !ana_pwr_o, "R8 digital power", int'(dig_pwr_o), 1);

        // both present: tie-break
        run_hs = 1; sel = 0; wait_n(20);
        chk(path_o == 2'b01, "R6 tie analog", int'(path_o), 1);
        sel = 1; wait_n(1);
        chk(path_o == 2'b10, "R6 tie digital", int'(path_o), 2);

        // override
        ovr = 1; sel = 0; run_hs = 0; wait_n(60);
        chk(path_o == 2'b01, "R4 override analog", int'(path_o), 1);
        sel = 1; wait_n(1);
        chk(path_o == 2'b10, "R4 override digital", int'(path_o), 2);
        ovr = 0; run_hs = 1;

        // power-down
        pwr_dn = 1; wait_n(2);
        chk(path_o == 2'b00 && !sense_pwr_o && lane_en_o == 3'b000, "R3 power-down", int'(path_o), 0);
        chk(!st_dlock_o, "R9 lock cleared by power-down", int'(st_dlock_o), 0);
        pwr_dn = 0;

        // data-enable gap restarts the count
        run_de = 1; wait_n(40);
        run_de = 0; wait_n(40);
        run_de = 1; wait_n(100);
        chk(!st_dlock_o, "R10 gap restart", int'(st_dlock_o), 0);
        wait_n(60);
        chk(st_dlock_o, "R10 relock", int'(st_dlock_o), 1);

        // link clock loss
        run_lclk = 0; wait_n(60);
        chk(!st_lclk_o && !st_dlock_o, "R9 clock loss", int'(st_dlock_o), 0);
        chk(path_o == 2'b01, "R5 back to analog", int'(path_o), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #1_500_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule